// File: doc/BRIEF.md
# Pipeline Exception Capture Unit

This block sits beside the control path of a small in-order 32-bit pipelined processor and handles the two faults that the pipeline can raise. The decode stage reports an instruction it cannot decode, and the execute stage reports a signed arithmetic overflow. In the cycle either flag is raised, the block takes the exception. It produces the write enables for a saved-PC register and a cause register, and the select for the cause code. It replaces the core's own next-PC selection with a handler choice, and it flushes the younger stages so that none of them reaches a stage that changes architectural state.

Each pipeline stage carries its instruction's PC+4 value, as a simple pipeline does. The block subtracts 4 from the PC+4 of the faulting stage, so the saved address names the offending instruction itself. When both stages fault together, the older instruction wins. That is the one in execute. The saved PC and cause registers are not visible to user code. Both read as zero after reset, and they change only in a cycle in which an exception is taken.

Top module: `exc_capture_unit`

## Requirements
- R1: A synchronous active-low reset clears the saved PC and the cause register to zero, whatever the fault flags are during reset.
- R2: An overflow raised in execute asserts the saved-PC write, the cause write and cause select 1 in the same cycle. After the next rising edge the cause register reads 1, and the saved PC reads the execute-stage PC+4 minus 4.
- R3: An illegal instruction raised in decode, with no overflow, asserts both writes and cause select 0 in the same cycle. After the next rising edge the cause register reads 0, and the saved PC reads the decode-stage PC+4 minus 4.
- R4: When overflow and illegal instruction are raised in the same cycle, the overflow is taken. The cause becomes 1 and the saved PC comes from the execute stage.
- R5: In a cycle with no fault flag, both write enables are low, and the saved PC and cause register keep their values.
- R6: The PC select output equals code 3 (handler) in any cycle in which an exception is taken, and otherwise passes the core's select through unchanged. The handler address output equals the HANDLER_ADDR parameter, which defaults to 32'h8000_0180.
- R7: An overflow asserts the fetch, decode and execute flush outputs in the same cycle.
- R8: An illegal instruction without overflow asserts the fetch and decode flushes and leaves the execute flush low.
- R9: The saved-PC subtraction wraps modulo 2^32. A faulting PC+4 of 0 saves 32'hFFFF_FFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| illegal_id | input | 1 | Decode stage holds an undecodable instruction |
| overflow_ex | input | 1 | Execute stage produced a signed overflow |
| pcp4_id | input | 32 | PC+4 of the decode-stage instruction |
| pcp4_ex | input | 32 | PC+4 of the execute-stage instruction |
| pc_src_in | input | 2 | Next-PC select chosen by the core |
| pc_src_out | output | 2 | Next-PC select after exception override (3 = handler) |
| handler_addr | output | 32 | Fixed handler address for the PC multiplexer |
| epc_we | output | 1 | Saved-PC write enable |
| cause_we | output | 1 | Cause register write enable |
| cause_sel | output | 1 | Cause code select (0 undefined instruction, 1 overflow) |
| flush_if | output | 1 | Squash the fetch-stage instruction |
| flush_id | output | 1 | Squash the decode-stage instruction |
| flush_ex | output | 1 | Squash the execute-stage instruction |
| epc | output | 32 | Saved PC of the faulting instruction |
| cause | output | 32 | Recorded cause code, zero-extended |

## Verification
The write enables, the cause select, the flushes and the PC select are combinational. They are due in the same cycle as the fault flags. The saved PC and the cause register are due one rising edge later. The bench therefore drives each vector on a falling edge and checks the control outputs a short delay later. It then checks the two registers just after the following rising edge, before it applies the next vector. Cycles with no fault follow cycles with a fault, so that the hold behaviour is seen at the register outputs.

// File: rtl/exc_pkg.sv
// Package: shared encodings for the exception capture unit.
// Assumes a 2-bit next-PC select, in which code 3 is reserved for the handler.
package exc_pkg;
    localparam int PCSEL_W = 2;
    localparam logic [PCSEL_W-1:0] PCSEL_HANDLER = 2'd3;

    typedef enum logic {
        CAUSE_UNDEF = 1'b0,
        CAUSE_OVF   = 1'b1
    } cause_e;
endpackage

// File: rtl/exc_detect.sv
// exc_detect: picks which fault is taken and which PC+4 belongs to it.
// Assumes the execute stage always holds an older instruction than decode.
module exc_detect #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            illegal_id,
    input  logic            overflow_ex,
    input  logic [XLEN-1:0] pcp4_id,
    input  logic [XLEN-1:0] pcp4_ex,
    output logic            take,
    output exc_pkg::cause_e cause_code,
    output logic [XLEN-1:0] fault_pcp4
);
    import exc_pkg::*;

    // Priority select: the older (execute) fault wins over decode.
    always_comb begin
        take       = overflow_ex | illegal_id;
        cause_code = overflow_ex ? CAUSE_OVF : CAUSE_UNDEF;
        fault_pcp4 = overflow_ex ? pcp4_ex : pcp4_id;
    end

    // R4: with both flags raised, the overflow cause is chosen
    p_prio_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_ex && illegal_id) |-> (cause_code == CAUSE_OVF));

    // R3: an illegal instruction alone selects code 0
    p_undef_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_id && !overflow_ex) |-> (cause_code == CAUSE_UNDEF));
endmodule

// File: rtl/exc_regs.sv
// exc_regs: the saved-PC and cause registers.
// Assumes the write enables are high only in a cycle in which a fault is taken.
// The saved PC is the fault's PC+4 minus 4, wrapping modulo 2^XLEN.
module exc_regs #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               epc_we,
    input  logic               cause_we,
    input  exc_pkg::cause_e    cause_code,
    input  logic [XLEN-1:0]    fault_pcp4,
    output logic [XLEN-1:0]    epc_q,
    output logic [CAUSE_W-1:0] cause_q
);
    import exc_pkg::*;

    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    logic [XLEN-1:0] epc_next;

    // Rewind PC+4 to the faulting instruction's address.
    always_comb epc_next = fault_pcp4 - INSN_BYTES;

    // Saved-PC register, loaded only on a taken fault.
    always_ff @(posedge clk) begin
        if (!rst_n)      epc_q <= '0;
        else if (epc_we) epc_q <= epc_next;
    end

    // Cause register, zero-extended cause code.
    always_ff @(posedge clk) begin
        if (!rst_n)        cause_q <= '0;
        else if (cause_we) cause_q <= CAUSE_W'(cause_code);
    end

    // R5: with no write, the saved PC holds its value
    p_epc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !epc_we |=> $stable(epc_q));

    // R5: with no write, the cause register holds its value
    p_cause_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_we |=> $stable(cause_q));

    // R2: a write loads PC+4 minus 4 on the next edge
    p_epc_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        epc_we |=> (epc_q == $past(fault_pcp4) - INSN_BYTES));
endmodule

// File: rtl/exc_redirect.sv
// exc_redirect: overrides the next-PC select and drives the squash signals.
// Assumes flushing execute also suppresses the faulting instruction's write-back.
module exc_redirect #(
    parameter int XLEN = 32,
    parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h8000_0180
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        take,
    input  exc_pkg::cause_e             cause_code,
    input  logic [exc_pkg::PCSEL_W-1:0] pc_src_in,
    output logic [exc_pkg::PCSEL_W-1:0] pc_src_out,
    output logic [XLEN-1:0]             handler_addr,
    output logic                        flush_if,
    output logic                        flush_id,
    output logic                        flush_ex
);
    import exc_pkg::*;

    // Next-PC override: the handler choice wins on any taken fault.
    always_comb begin
        pc_src_out   = take ? PCSEL_HANDLER : pc_src_in;
        handler_addr = HANDLER_ADDR;
    end

    // Squash every stage younger than the fault, and execute itself on overflow.
    always_comb begin
        flush_if = take;
        flush_id = take;
        flush_ex = take && (cause_code == CAUSE_OVF);
    end

    // R7: an execute flush always comes with the younger flushes
    p_flush_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ex |-> (flush_id && flush_if));

    // R6: no flush without a redirect to the handler
    p_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_if |-> (pc_src_out == PCSEL_HANDLER));
endmodule

// File: rtl/exc_capture_unit.sv
// exc_capture_unit: top of the exception capture unit.
// Ties fault selection, the saved-PC and cause registers, and the redirect together.
// Assumes each stage's PC+4 is valid whenever that stage's fault flag is high.
module exc_capture_unit #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 32,
    parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h8000_0180
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               illegal_id,
    input  logic               overflow_ex,
    input  logic [XLEN-1:0]    pcp4_id,
    input  logic [XLEN-1:0]    pcp4_ex,
    input  logic [1:0]         pc_src_in,
    output logic [1:0]         pc_src_out,
    output logic [XLEN-1:0]    handler_addr,
    output logic               epc_we,
    output logic               cause_we,
    output logic               cause_sel,
    output logic               flush_if,
    output logic               flush_id,
    output logic               flush_ex,
    output logic [XLEN-1:0]    epc,
    output logic [CAUSE_W-1:0] cause
);
    import exc_pkg::*;

    logic            take;
    cause_e          cause_code;
    logic [XLEN-1:0] fault_pcp4;

    exc_detect #(.XLEN(XLEN)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .illegal_id  (illegal_id),
        .overflow_ex (overflow_ex),
        .pcp4_id     (pcp4_id),
        .pcp4_ex     (pcp4_ex),
        .take        (take),
        .cause_code  (cause_code),
        .fault_pcp4  (fault_pcp4)
    );

    // Capture controls exported to the datapath.
    always_comb begin
        epc_we    = take;
        cause_we  = take;
        cause_sel = (cause_code == CAUSE_OVF);
    end

    exc_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .epc_we     (epc_we),
        .cause_we   (cause_we),
        .cause_code (cause_code),
        .fault_pcp4 (fault_pcp4),
        .epc_q      (epc),
        .cause_q    (cause)
    );

    exc_redirect #(.XLEN(XLEN), .HANDLER_ADDR(HANDLER_ADDR)) u_redirect (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (take),
        .cause_code   (cause_code),
        .pc_src_in    (pc_src_in),
        .pc_src_out   (pc_src_out),
        .handler_addr (handler_addr),
        .flush_if     (flush_if),
        .flush_id     (flush_id),
        .flush_ex     (flush_ex)
    );

    // R1: the registers read zero in the cycle after a reset edge
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (epc == '0 && cause == '0));

    // R2: an overflow leaves cause code 1 on the next edge
    p_ovf_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_ex |=> (cause == CAUSE_W'(1)));
endmodule

// File: tb/test_exc_capture_unit.sv
// Bench for exc_capture_unit: a vector table walked by one loop, then directed reset checks.
module test_exc_capture_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        illegal_id, overflow_ex;
    logic [31:0] pcp4_id, pcp4_ex;
    logic [1:0]  pc_src_in, pc_src_out;
    logic [31:0] handler_addr, epc, cause;
    logic        epc_we, cause_we, cause_sel, flush_if, flush_id, flush_ex;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_capture_unit i_exc_capture_unit (
        .clk(clk), .rst_n(rst_n), .illegal_id(illegal_id), .overflow_ex(overflow_ex),
        .pcp4_id(pcp4_id), .pcp4_ex(pcp4_ex), .pc_src_in(pc_src_in),
        .pc_src_out(pc_src_out), .handler_addr(handler_addr), .epc_we(epc_we),
        .cause_we(cause_we), .cause_sel(cause_sel), .flush_if(flush_if),
        .flush_id(flush_id), .flush_ex(flush_ex), .epc(epc), .cause(cause)
    );

    typedef struct packed {
        logic        ovf;
        logic        ill;
        logic [31:0] id_p4;
        logic [31:0] ex_p4;
        logic [1:0]  psrc;
        logic [2:0]  exp_flush;  // {if, id, ex}
        logic [1:0]  exp_psel;
        logic [31:0] exp_epc;
        logic [31:0] exp_cause;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 32'h0000_0104, 32'h0000_0100, 2'd0, 3'b000, 2'd0, 32'h0000_0000, 32'd0}, // R5
        '{1'b1, 1'b0, 32'h0040_0024, 32'h0040_0020, 2'd1, 3'b111, 2'd3, 32'h0040_001C, 32'd1}, // R2 R7
        '{1'b0, 1'b0, 32'h0040_0028, 32'h0040_0024, 2'd2, 3'b000, 2'd2, 32'h0040_001C, 32'd1}, // R5
        '{1'b0, 1'b1, 32'h0040_0108, 32'h0040_0104, 2'd0, 3'b110, 2'd3, 32'h0040_0104, 32'd0}, // R3 R8
        '{1'b1, 1'b1, 32'h0000_1010, 32'h0000_100C, 2'd1, 3'b111, 2'd3, 32'h0000_1008, 32'd1}, // R4
        '{1'b0, 1'b1, 32'h0000_0000, 32'h0000_0FFC, 2'd2, 3'b110, 2'd3, 32'hFFFF_FFFC, 32'd0}, // R9
        '{1'b0, 1'b0, 32'h1234_5678, 32'h8765_4320, 2'd1, 3'b000, 2'd1, 32'hFFFF_FFFC, 32'd0}, // R5
        '{1'b1, 1'b0, 32'h0000_0008, 32'h0000_0004, 2'd0, 3'b111, 2'd3, 32'h0000_0000, 32'd1}, // R2
        '{1'b0, 1'b0, 32'h0000_0010, 32'h0000_000C, 2'd3, 3'b000, 2'd3, 32'h0000_0000, 32'd1}  // R6
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.ovf && v.ill) return "R4";
        if (v.ovf)          return "R2/R7";
        if (v.ill)          return "R3/R8";
        return "R5/R6";
    endfunction

    initial begin
        #(CLK_PERIOD * 2000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; illegal_id = 1'b1; overflow_ex = 1'b1;
        pcp4_id = 32'h55; pcp4_ex = 32'h99; pc_src_in = 2'd0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset clears the registers even while faults are raised
        check(epc == 32'h0, "R1", "epc after reset", epc, 32'h0);
        check(cause == 32'h0, "R1", "cause after reset", cause, 32'h0);
        @(negedge clk);
        rst_n = 1'b1; illegal_id = 1'b0; overflow_ex = 1'b0;
        // R6: handler address parameter default
        #1 check(handler_addr == 32'h8000_0180, "R6", "handler_addr", handler_addr, 32'h8000_0180);

        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            logic exp_take;
            v = VECS[i];
            exp_take = v.ovf | v.ill;
            @(negedge clk);
            overflow_ex = v.ovf; illegal_id = v.ill;
            pcp4_id = v.id_p4; pcp4_ex = v.ex_p4; pc_src_in = v.psrc;
            #1;
            check({flush_if, flush_id, flush_ex} == v.exp_flush, tag_of(v), "flushes",
                  32'({flush_if, flush_id, flush_ex}), 32'(v.exp_flush));
            check(pc_src_out == v.exp_psel, tag_of(v), "pc_src_out",
                  32'(pc_src_out), 32'(v.exp_psel));
            check(epc_we == exp_take && cause_we == exp_take, tag_of(v), "write enables",
                  32'({epc_we, cause_we}), 32'({exp_take, exp_take}));
            if (exp_take)
                check(cause_sel == v.ovf, tag_of(v), "cause_sel", 32'(cause_sel), 32'(v.ovf));
            @(posedge clk);
            #1;
            check(epc == v.exp_epc, tag_of(v), "epc", epc, v.exp_epc);
            check(cause == v.exp_cause, tag_of(v), "cause", cause, v.exp_cause);
        end

        // R1: reset in mid-run clears nonzero state while a fault is raised
        @(negedge clk);
        overflow_ex = 1'b1; pcp4_ex = 32'h0000_0200;
        @(posedge clk);
        #1 check(epc == 32'h0000_01FC, "R2", "epc before reset", epc, 32'h0000_01FC);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(epc == 32'h0, "R1", "epc mid-run reset", epc, 32'h0);
        check(cause == 32'h0, "R1", "cause mid-run reset", cause, 32'h0);
        @(negedge clk);
        rst_n = 1'b1; overflow_ex = 1'b0;
        @(posedge clk);
        #1 check(epc == 32'h0, "R5", "epc hold after reset", epc, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule